// File: doc/BRIEF.md
# Warp Branch Divergence Mask Unit

This block keeps the active-lane mask of one warp while the warp runs a two-way conditional. All lanes share a single fetch and decode path, so the two sides of a branch cannot run together. The unit runs them one after the other. The taken ("then") side runs first, with only the lanes whose predicate is true enabled. The "else" side runs next, with only the predicate-false lanes enabled. When the branch ends, the mask held before the branch is restored. Each branch whose lanes disagree therefore costs the time of both sides.

An external sequencer drives three strobes: branch open, then-side finished and else-side finished. It also supplies one predicate bit per lane on the open strobe. A side whose lane set is empty is not run. The unit signals this with a one-cycle skip pulse, so a branch where all active lanes agree takes a single phase. Nested branches are held on a small LIFO of saved masks. Protocol misuse raises a one-cycle error pulse and leaves all state unchanged.

Top module: `simt_divmask_unit`

## Requirements
- R1: After reset the active mask has every lane set, the nesting level is 0, the else-phase indicator is 0, and the skip and error pulses are low.
- R2: An accepted branch open with at least one lane in (current mask AND predicate) sets the active mask to that value on the next cycle, raises the nesting level by one and leaves the else-phase indicator at 0.
- R3: A then-finished strobe during a then-phase whose else set (pre-branch mask AND NOT predicate) is non-empty sets the active mask to that else set and sets the else-phase indicator to 1. The nesting level does not change.
- R4: An else-finished strobe during an else-phase restores the mask held before the innermost open branch and lowers the nesting level by one.
- R5: If every active lane takes the then side, the then-finished strobe restores the pre-branch mask at once, lowers the level, and pulses the skip flag.
- R6: If no active lane takes the then side, the open strobe goes straight to the else phase (mask = else set, indicator 1, level +1) and pulses the skip flag.
- R7: Up to 4 branches nest; each close restores the mask of its own level in last-in first-out order.
- R8: A branch open while 4 levels are held pulses the error flag and changes neither the mask nor the level.
- R9: A then-finished or else-finished strobe at level 0 pulses the error flag and changes nothing.
- R10: An else-finished strobe during a then-phase, or a then-finished strobe during an else-phase, pulses the error flag and changes nothing.
- R11: Two or more strobes in the same cycle pulse the error flag and change nothing.
- R12: Skip and error are single-cycle pulses that appear in the cycle after the strobe that caused them, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_pred | input | 32 | Per-lane branch condition, sampled with br_open |
| br_open | input | 1 | Branch start strobe |
| then_done | input | 1 | Then side finished strobe |
| else_done | input | 1 | Else side finished strobe |
| active_mask | output | 32 | Lanes enabled for execution |
| in_else | output | 1 | 1 while the innermost branch runs its else side |
| nest_level | output | 3 | Number of open branches |
| path_skip | output | 1 | Pulse: a side with no lanes was skipped |
| seq_err | output | 1 | Pulse: strobe rejected |

## Verification
The embedded properties check several rules on every cycle. The nesting level never passes the stack depth, and each accepted open adds exactly one level. Inside a branch the active lanes stay a subset of the saved pre-branch mask. The else mask shares no lane with the then mask it replaces. A rejected strobe leaves the mask untouched, and skip and error never pulse together. The directed scenarios are needed to show the actual mask values. These include the split under mixed, all-true and all-false predicates, last-in first-out restoration across four levels, and the exact cycle in which each pulse rises and falls.

// File: rtl/simt_dm_pkg.sv
package simt_dm_pkg;
   typedef enum logic [2:0] {
      CMD_IDLE  = 3'd0,
      CMD_OPEN  = 3'd1,
      CMD_FLIP  = 3'd2,
      CMD_CLOSE = 3'd3,
      CMD_CLASH = 3'd4
   } dm_cmd_e;
endpackage

// File: rtl/dm_strobe_dec.sv
module dm_strobe_dec
   import simt_dm_pkg::*;
(
   input  logic    open_i,
   input  logic    then_i,
   input  logic    else_i,
   output dm_cmd_e cmd_o
);
   logic [1:0] hits;

   always_comb begin
      hits = {1'b0, open_i} + {1'b0, then_i} + {1'b0, else_i};
      if (hits > 2'd1)   cmd_o = CMD_CLASH;
      else if (open_i)   cmd_o = CMD_OPEN;
      else if (then_i)   cmd_o = CMD_FLIP;
      else if (else_i)   cmd_o = CMD_CLOSE;
      else               cmd_o = CMD_IDLE;
   end
endmodule

// File: rtl/dm_lane_split.sv
module dm_lane_split #(
   parameter int LANES     = 32,
   parameter bit PER_LANE  = 1'b1
) (
   input  logic [LANES-1:0] cur_i,
   input  logic [LANES-1:0] pred_i,
   output logic [LANES-1:0] then_o,
   output logic [LANES-1:0] else_o,
   output logic             then_any_o,
   output logic             else_any_o
);
   if (LANES < 1) begin : g_bad_lanes
      $error("dm_lane_split: LANES must be at least 1");
   end

   if (PER_LANE) begin : g_lane
      for (genvar l = 0; l < LANES; l++) begin : g_bit
         assign then_o[l] = cur_i[l] &  pred_i[l];
         assign else_o[l] = cur_i[l] & ~pred_i[l];
      end
   end else begin : g_vec
      assign then_o = cur_i &  pred_i;
      assign else_o = cur_i & ~pred_i;
   end

   assign then_any_o = |then_o;
   assign else_any_o = |else_o;
endmodule

// File: rtl/dm_mask_stack.sv
module dm_mask_stack #(
   parameter int LANES = 32,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             mark_else_i,
   input  logic [LANES-1:0] push_restore_i,
   input  logic [LANES-1:0] push_else_i,
   input  logic             push_in_else_i,
   output logic [LANES-1:0] top_restore_o,
   output logic [LANES-1:0] top_else_o,
   output logic             top_in_else_o,
   output logic [$clog2(DEPTH+1)-1:0] level_o,
   output logic             full_o,
   output logic             empty_o
);
   localparam int LW = $clog2(DEPTH+1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("dm_mask_stack: DEPTH must be at least 2");
   end

   logic [LANES-1:0] restore_mem [DEPTH];
   logic [LANES-1:0] else_mem    [DEPTH];
   logic [DEPTH-1:0] phase_mem;
   logic [LW-1:0]    level_q;
   logic [LW-1:0]    level_m1;
   logic [IW-1:0]    top_idx;
   logic [IW-1:0]    wr_idx;

   assign level_m1 = level_q - LW'(1);
   assign top_idx  = level_m1[IW-1:0];
   assign wr_idx   = level_q[IW-1:0];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            restore_mem[e] <= '0;
            else_mem[e]    <= '0;
            phase_mem[e]   <= 1'b0;
         end else if (push_i && wr_idx == IW'(e)) begin
            restore_mem[e] <= push_restore_i;
            else_mem[e]    <= push_else_i;
            phase_mem[e]   <= push_in_else_i;
         end else if (mark_else_i && top_idx == IW'(e)) begin
            phase_mem[e]   <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      level_q <= '0;
      else if (push_i) level_q <= level_q + LW'(1);
      else if (pop_i)  level_q <= level_m1;
   end

   assign empty_o       = (level_q == '0);
   assign full_o        = (level_q == LW'(DEPTH));
   assign top_restore_o = empty_o ? '1   : restore_mem[top_idx];
   assign top_else_o    = empty_o ? '0   : else_mem[top_idx];
   assign top_in_else_o = empty_o ? 1'b0 : phase_mem[top_idx];
   assign level_o       = level_q;

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LW'(DEPTH));

   // R2
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> (level_q == $past(level_q) + LW'(1)));

   // R8
   push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));
endmodule

// File: rtl/dm_seq_ctrl.sv
module dm_seq_ctrl
   import simt_dm_pkg::*;
#(
   parameter int LANES = 32,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dm_cmd_e          cmd_i,
   input  logic [LANES-1:0] then_m_i,
   input  logic [LANES-1:0] else_m_i,
   input  logic             then_any_i,
   input  logic             else_any_i,
   input  logic [LANES-1:0] top_restore_i,
   input  logic [LANES-1:0] top_else_i,
   input  logic             top_in_else_i,
   input  logic             full_i,
   input  logic             empty_i,
   output logic [LANES-1:0] active_o,
   output logic             push_o,
   output logic             pop_o,
   output logic             mark_else_o,
   output logic             push_in_else_o,
   output logic             skip_o,
   output logic             err_o
);
   logic [LANES-1:0] active_q, active_d;
   logic             skip_d, err_d, skip_q, err_q;

   always_comb begin
      active_d       = active_q;
      push_o         = 1'b0;
      pop_o          = 1'b0;
      mark_else_o    = 1'b0;
      push_in_else_o = 1'b0;
      skip_d         = 1'b0;
      err_d          = 1'b0;
      unique case (cmd_i)
         CMD_CLASH: err_d = 1'b1;
         CMD_OPEN: begin
            if (full_i) begin
               err_d = 1'b1;
            end else if (then_any_i) begin
               push_o   = 1'b1;
               active_d = then_m_i;
            end else if (else_any_i) begin
               push_o         = 1'b1;
               push_in_else_o = 1'b1;
               active_d       = else_m_i;
               skip_d         = 1'b1;
            end else begin
               skip_d = 1'b1;
            end
         end
         CMD_FLIP: begin
            if (empty_i || top_in_else_i) begin
               err_d = 1'b1;
            end else if (top_else_i != '0) begin
               mark_else_o = 1'b1;
               active_d    = top_else_i;
            end else begin
               pop_o    = 1'b1;
               active_d = top_restore_i;
               skip_d   = 1'b1;
            end
         end
         CMD_CLOSE: begin
            if (empty_i || !top_in_else_i) begin
               err_d = 1'b1;
            end else begin
               pop_o    = 1'b1;
               active_d = top_restore_i;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= '1;
         skip_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         active_q <= active_d;
         skip_q   <= skip_d;
         err_q    <= err_d;
      end
   end

   assign active_o = active_q;
   assign skip_o   = skip_q;
   assign err_o    = err_q;

   // R3
   flip_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mark_else_o |=> ((active_q & $past(active_q)) == '0));

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> $stable(active_q));

   // R12
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(skip_q && err_q));

   // R7
   nest_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_i |-> ((active_q & ~top_restore_i) == '0));
endmodule

// File: rtl/simt_divmask_unit.sv
module simt_divmask_unit
   import simt_dm_pkg::*;
#(
   parameter int LANES    = 32,
   parameter int DEPTH    = 4,
   parameter bit PER_LANE = 1'b1,
   localparam int LW      = $clog2(DEPTH+1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_pred,
   input  logic             br_open,
   input  logic             then_done,
   input  logic             else_done,
   output logic [LANES-1:0] active_mask,
   output logic             in_else,
   output logic [LW-1:0]    nest_level,
   output logic             path_skip,
   output logic             seq_err
);
   dm_cmd_e          cmd;
   logic [LANES-1:0] then_m, else_m, top_restore, top_else, cur;
   logic             then_any, else_any, top_in_else, full, empty;
   logic             push, pop, mark_else, push_in_else;

   dm_strobe_dec u_dec (
      .open_i (br_open),
      .then_i (then_done),
      .else_i (else_done),
      .cmd_o  (cmd)
   );

   dm_lane_split #(.LANES(LANES), .PER_LANE(PER_LANE)) u_split (
      .cur_i      (cur),
      .pred_i     (lane_pred),
      .then_o     (then_m),
      .else_o     (else_m),
      .then_any_o (then_any),
      .else_any_o (else_any)
   );

   dm_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
      .clk            (clk),
      .rst_n          (rst_n),
      .push_i         (push),
      .pop_i          (pop),
      .mark_else_i    (mark_else),
      .push_restore_i (cur),
      .push_else_i    (else_m),
      .push_in_else_i (push_in_else),
      .top_restore_o  (top_restore),
      .top_else_o     (top_else),
      .top_in_else_o  (top_in_else),
      .level_o        (nest_level),
      .full_o         (full),
      .empty_o        (empty)
   );

   dm_seq_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_i          (cmd),
      .then_m_i       (then_m),
      .else_m_i       (else_m),
      .then_any_i     (then_any),
      .else_any_i     (else_any),
      .top_restore_i  (top_restore),
      .top_else_i     (top_else),
      .top_in_else_i  (top_in_else),
      .full_i         (full),
      .empty_i        (empty),
      .active_o       (cur),
      .push_o         (push),
      .pop_o          (pop),
      .mark_else_o    (mark_else),
      .push_in_else_o (push_in_else),
      .skip_o         (path_skip),
      .err_o          (seq_err)
   );

   assign active_mask = cur;
   assign in_else     = top_in_else;
endmodule

// File: tb/simt_divmask_unit_tb.sv
module simt_divmask_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lane_pred = '0;
   logic        br_open = 1'b0, then_done = 1'b0, else_done = 1'b0;
   logic [31:0] active_mask;
   logic        in_else, path_skip, seq_err;
   logic [2:0]  nest_level;
   int          total = 0;
   int          bad = 0;

   always #2.5 clk = ~clk;

   simt_divmask_unit dut_i (
      .clk(clk), .rst_n(rst_n), .lane_pred(lane_pred),
      .br_open(br_open), .then_done(then_done), .else_done(else_done),
      .active_mask(active_mask), .in_else(in_else), .nest_level(nest_level),
      .path_skip(path_skip), .seq_err(seq_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive strobes for one cycle; returns at the negedge after the capturing edge
   task automatic cyc(input logic [31:0] p, input logic s, input logic t, input logic e);
      lane_pred = p; br_open = s; then_done = t; else_done = e;
      @(negedge clk);
      br_open = 1'b0; then_done = 1'b0; else_done = 1'b0;
   endtask

   task automatic state(input string tag, input logic [31:0] m, input int lvl,
                        input logic ie, input logic sk, input logic er);
      chk({tag, " mask"},  active_mask, m);
      chk({tag, " level"}, {29'd0, nest_level}, lvl);
      chk({tag, " else"},  {31'd0, in_else}, {31'd0, ie});
      chk({tag, " skip"},  {31'd0, path_skip}, {31'd0, sk});
      chk({tag, " err"},   {31'd0, seq_err}, {31'd0, er});
   endtask

   task automatic t_reset;
      state("R1 reset", 32'hFFFF_FFFF, 0, 0, 0, 0);
   endtask

   task automatic t_diverge;
      cyc(32'hA5A5_A5A5, 1, 0, 0);
      state("R2 open", 32'hA5A5_A5A5, 1, 0, 0, 0);
      cyc('0, 0, 1, 0);
      state("R3 flip", 32'h5A5A_5A5A, 1, 1, 0, 0);
      cyc('0, 0, 0, 1);
      state("R4 close", 32'hFFFF_FFFF, 0, 0, 0, 0);
   endtask

   task automatic t_uniform_true;
      cyc(32'hFFFF_FFFF, 1, 0, 0);
      state("R5 open", 32'hFFFF_FFFF, 1, 0, 0, 0);
      cyc('0, 0, 1, 0);
      state("R5 skip else", 32'hFFFF_FFFF, 0, 0, 1, 0);
      cyc('0, 0, 0, 0);
      state("R12 skip drop", 32'hFFFF_FFFF, 0, 0, 0, 0);
   endtask

   task automatic t_uniform_false;
      cyc(32'h0000_0000, 1, 0, 0);
      state("R6 skip then", 32'hFFFF_FFFF, 1, 1, 1, 0);
      cyc('0, 0, 0, 1);
      state("R6 close", 32'hFFFF_FFFF, 0, 0, 0, 0);
   endtask

   task automatic t_nest;
      cyc(32'h0000_FFFF, 1, 0, 0);
      cyc(32'h00FF_00FF, 1, 0, 0);
      state("R7 inner open", 32'h0000_00FF, 2, 0, 0, 0);
      cyc('0, 0, 1, 0);
      state("R7 inner flip", 32'h0000_FF00, 2, 1, 0, 0);
      cyc('0, 0, 0, 1);
      state("R7 inner close", 32'h0000_FFFF, 1, 0, 0, 0);
      cyc(32'hFFFF_0000, 1, 0, 0);
      state("R6 nested empty then", 32'h0000_FFFF, 2, 1, 1, 0);
      cyc('0, 0, 0, 1);
      cyc('0, 0, 1, 0);
      state("R7 outer flip", 32'hFFFF_0000, 1, 1, 0, 0);
      cyc('0, 0, 0, 1);
      state("R7 outer close", 32'hFFFF_FFFF, 0, 0, 0, 0);
   endtask

   task automatic t_overflow;
      cyc(32'hFFFF_FFFE, 1, 0, 0);
      cyc(32'h7FFF_FFFF, 1, 0, 0);
      cyc(32'h0000_FFFF, 1, 0, 0);
      cyc(32'h0000_00FF, 1, 0, 0);
      state("R7 depth4", 32'h0000_00FE, 4, 0, 0, 0);
      cyc(32'h0000_0001, 1, 0, 0);
      state("R8 overflow", 32'h0000_00FE, 4, 0, 0, 1);
      cyc('0, 0, 0, 0);
      chk("R12 err drop", {31'd0, seq_err}, 32'd0);
      cyc('0, 0, 1, 0);
      chk("R7 l4 else", active_mask, 32'h0000_FF00);
      cyc('0, 0, 0, 1);
      chk("R7 l3 back", active_mask, 32'h0000_FFFE);
      cyc('0, 0, 1, 0);
      chk("R7 l3 else", active_mask, 32'h7FFF_0000);
      cyc('0, 0, 0, 1);
      cyc('0, 0, 1, 0);
      chk("R7 l2 else", active_mask, 32'h8000_0000);
      cyc('0, 0, 0, 1);
      cyc('0, 0, 1, 0);
      chk("R7 l1 else", active_mask, 32'h0000_0001);
      cyc('0, 0, 0, 1);
      state("R7 unwound", 32'hFFFF_FFFF, 0, 0, 0, 0);
   endtask

   task automatic t_underflow;
      cyc('0, 0, 1, 0);
      state("R9 then empty", 32'hFFFF_FFFF, 0, 0, 0, 1);
      cyc('0, 0, 0, 1);
      state("R9 else empty", 32'hFFFF_FFFF, 0, 0, 0, 1);
   endtask

   task automatic t_order;
      cyc(32'hF0F0_F0F0, 1, 0, 0);
      cyc('0, 0, 0, 1);
      state("R10 else in then", 32'hF0F0_F0F0, 1, 0, 0, 1);
      cyc('0, 0, 1, 0);
      state("R10 flip ok", 32'h0F0F_0F0F, 1, 1, 0, 0);
      cyc('0, 0, 1, 0);
      state("R10 then in else", 32'h0F0F_0F0F, 1, 1, 0, 1);
      cyc('0, 0, 0, 1);
      state("R10 close", 32'hFFFF_FFFF, 0, 0, 0, 0);
   endtask

   task automatic t_multi;
      cyc(32'h0000_000F, 1, 1, 0);
      state("R11 clash", 32'hFFFF_FFFF, 0, 0, 0, 1);
      cyc(32'h0000_000F, 1, 0, 0);
      cyc('0, 0, 1, 1);
      state("R11 clash nested", 32'h0000_000F, 1, 0, 0, 1);
      cyc('0, 0, 1, 0);
      cyc('0, 0, 0, 1);
      state("R11 recover", 32'hFFFF_FFFF, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_diverge();
      t_uniform_true();
      t_uniform_false();
      t_nest();
      t_overflow();
      t_underflow();
      t_order();
      t_multi();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule